// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block takes the data phase of a serial write command and turns it into one timed commit of a whole memory page. A front end that has already decoded the serial bus hands it a command start with a 12-bit word address, a strobe for each data byte, and a single event when the bus Stop closes the command. The bytes land in a 32-entry page latch at the offset held in the low five bits of an address pointer. That offset steps by one per byte and wraps inside the page, so the upper seven address bits never change during a command.

On Stop, the block samples the write-protect input. If protection is off and at least one byte was buffered, it enters a write cycle of fixed length (`WC_CYCLES` clocks) and holds `busy` high for all of it. At the start of the cycle it issues one array write strobe per page offset, in ascending order. Offsets that received a byte take the buffered value. Offsets that did not are rewritten with the array's current content, so the whole page is cycled. The byte-wide array is modelled in registers inside the block, and a combinational read port lets the surrounding logic fetch any location.

The controller is a four-state machine:
- IDLE waits for a command start (transition *open*).
- COLLECT buffers bytes. A repeated start restarts the command (*restart*). Stop with buffered data and protection off goes to PROGRAM (*commit*). Any other Stop returns to IDLE (*discard*).
- PROGRAM walks the page offsets and moves to SETTLE after the last offset (*walked*).
- SETTLE waits until the cycle length is used up, then returns to IDLE (*done*).

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, `busy` and `arr_we` are 0, `addr_ptr` is 0, and every array location reads 0.
- R2: A command start loads `addr_ptr` from `cmd_addr`. Each accepted byte is stored at page offset `addr_ptr[4:0]`, after which bits [4:0] increment modulo 32 and bits [11:5] stay unchanged.
- R3: When more than 32 bytes arrive in one command, the offset wraps to 0 of the same page and later bytes replace earlier ones, so each offset holds the last byte written to it.
- R4: A commit issues exactly 32 array write strobes, at page offsets 0 through 31 in order, within the page `addr_ptr[11:5]`. Buffered offsets receive their byte, unbuffered offsets keep their old value, and other pages are untouched.
- R5: A Stop that ends a command carrying no data bytes starts no write cycle: `busy` stays 0 and the array is unchanged.
- R6: If `wp` is 1 in the cycle where Stop is seen, no cycle runs, nothing is written, and `busy` stays 0, so a new command is accepted in the very next cycle.
- R7: Changing `wp` while a write cycle is running has no effect on that cycle or on the data committed.
- R8: `busy` rises in the cycle after an accepted Stop and stays high for exactly `WC_CYCLES` clock cycles.
- R9: While `busy` is 1, command starts, byte strobes and Stop events are ignored: `addr_ptr` and the committed data are unaffected.
- R10: After a command ends, `addr_ptr` holds the page address with offset (start offset + bytes accepted) modulo 32, that is, the location after the last byte written, wrapped within the page.
- R11: A command start during an open command discards all bytes buffered so far and reloads the pointer. Only bytes after the new start are committed.
- R12: Byte strobes and Stop events that arrive while no command is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse: a write command begins |
| cmd_addr | input | 12 | Word address carried by the command |
| byte_valid | input | 1 | One-cycle strobe: `byte_data` is a data byte |
| byte_data | input | 8 | Data byte |
| stop_evt | input | 1 | One-cycle pulse: Stop ended the command |
| wp | input | 1 | Write protect, sampled only with `stop_evt` |
| rd_addr | input | 12 | Array read address |
| rd_data | output | 8 | Array content at `rd_addr` (combinational) |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | 12 | Array write address |
| arr_wdata | output | 8 | Array write data |
| addr_ptr | output | 12 | Current address pointer |

## Verification
Each fault inside the block shows up at the ports within one command. A wrong offset step or a carry into the page bits shows up at `addr_ptr` in the cycle after the byte strobe. A wrong valid mask or latch slot is seen only after the commit, when the page is read back through `rd_addr` and an old byte has been clobbered or a new one is missing. A bad timer or state decode changes the number of cycles `busy` is high, or the number of `arr_we` strobes, within the same write cycle. Leaked protection or a leaked Stop shows up as `busy` rising, or as array content changing, in the cycle after the Stop.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROGRAM = 2'd2,
        ST_SETTLE  = 2'd3
    } pwc_state_e;

endpackage

// File: rtl/pwc_array.sv
module pwc_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/pwc_latch.sv
module pwc_latch #(
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PAGE_W-1:0] rd_off,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit,
    output logic              any_written
);
    localparam int SLOTS = 1 << PAGE_W;

    logic [DATA_W-1:0] slot_data [SLOTS];
    logic [SLOTS-1:0]  slot_vld;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] d_q;
        logic              v_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_off == PAGE_W'(g))) begin
                d_q <= wr_data;
                v_q <= 1'b1;
            end
        end

        assign slot_data[g] = d_q;
        assign slot_vld[g]  = v_q;
    end

    assign rd_data     = slot_data[rd_off];
    assign rd_hit      = slot_vld[rd_off];
    assign any_written = |slot_vld;

    // R11
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_written);

    // R3
    last_byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> slot_data[$past(wr_off)] == $past(wr_data));

endmodule

// File: rtl/pwc_ptr.sv
module pwc_ptr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              inc,
    input  logic              busy,
    output logic [ADDR_W-1:0] ptr
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic [PG_W-1:0]   page_q;
    logic [PAGE_W-1:0] off_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            page_q <= load_addr[ADDR_W-1:PAGE_W];
            off_q  <= load_addr[PAGE_W-1:0];
        end else if (inc) begin
            off_q  <= off_q + PAGE_W'(1);
        end
    end

    assign ptr = {page_q, off_q};

    // R2
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))
                        && (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));

    // R9
    ptr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

endmodule

// File: rtl/pwc_fsm.sv
module pwc_fsm
    import pwc_pkg::*;
#(
    parameter int PAGE_W    = 5,
    parameter int WC_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              byte_valid,
    input  logic              stop_evt,
    input  logic              wp,
    input  logic              any_buffered,
    output logic              busy,
    output logic              load_ptr,
    output logic              accept_byte,
    output logic              clr_latch,
    output logic              commit_we,
    output logic [PAGE_W-1:0] commit_off
);
    localparam int TMR_W = $clog2(WC_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WC_CYCLES - 1);

    pwc_state_e        state_q, state_d;
    logic [TMR_W-1:0]  tmr_q;
    logic [PAGE_W-1:0] idx_q;
    logic              tmr_done;
    logic              idx_last;

    assign tmr_done = (tmr_q == TMR_LAST);
    assign idx_last = (idx_q == '1);

    // state register, cycle timer and commit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PROGRAM || state_q == ST_SETTLE) begin
                tmr_q <= tmr_q + TMR_W'(1);
            end else begin
                tmr_q <= '0;
            end
            if (state_q == ST_PROGRAM) begin
                idx_q <= idx_q + PAGE_W'(1);
            end else begin
                idx_q <= '0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_COLLECT;              // open
            end
            ST_COLLECT: begin
                if (cmd_start) begin
                    state_d = ST_COLLECT;                         // restart
                end else if (stop_evt) begin
                    if (any_buffered && !wp) state_d = ST_PROGRAM; // commit
                    else                     state_d = ST_IDLE;    // discard
                end
            end
            ST_PROGRAM: begin
                if (idx_last) state_d = tmr_done ? ST_IDLE : ST_SETTLE; // walked
            end
            ST_SETTLE: begin
                if (tmr_done) state_d = ST_IDLE;                  // done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy        = 1'b0;
        load_ptr    = 1'b0;
        accept_byte = 1'b0;
        commit_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_ptr = cmd_start;
            end
            ST_COLLECT: begin
                load_ptr    = cmd_start;
                accept_byte = byte_valid && !cmd_start && !stop_evt;
            end
            ST_PROGRAM: begin
                busy      = 1'b1;
                commit_we = 1'b1;
            end
            ST_SETTLE: begin
                busy = 1'b1;
            end
            default: ;
        endcase
    end

    assign clr_latch  = load_ptr;
    assign commit_off = idx_q;

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt && !wp && any_buffered));

    // R5 R6
    no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && stop_evt && !cmd_start && (wp || !any_buffered))
            |=> (!busy && state_q == ST_IDLE));

    // R8
    timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (tmr_q <= TMR_LAST));

    // R4
    commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_we && $past(commit_we)) |-> commit_off == PAGE_W'($past(commit_off) + 1'b1));

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl #(
    parameter int ADDR_W    = 12,
    parameter int PAGE_W    = 5,
    parameter int DATA_W    = 8,
    parameter int WC_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_evt,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] addr_ptr
);
    localparam int PG_W = ADDR_W - PAGE_W;

    logic              load_ptr;
    logic              accept_byte;
    logic              clr_latch;
    logic              commit_we;
    logic [PAGE_W-1:0] commit_off;
    logic              any_buffered;
    logic [DATA_W-1:0] latch_byte;
    logic              latch_hit;
    logic [DATA_W-1:0] old_byte;
    logic [PG_W-1:0]   cur_page;
    logic [ADDR_W-1:0] commit_addr;

    pwc_fsm #(
        .PAGE_W    (PAGE_W),
        .WC_CYCLES (WC_CYCLES)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_start    (cmd_start),
        .byte_valid   (byte_valid),
        .stop_evt     (stop_evt),
        .wp           (wp),
        .any_buffered (any_buffered),
        .busy         (busy),
        .load_ptr     (load_ptr),
        .accept_byte  (accept_byte),
        .clr_latch    (clr_latch),
        .commit_we    (commit_we),
        .commit_off   (commit_off)
    );

    pwc_ptr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ptr),
        .load_addr (cmd_addr),
        .inc       (accept_byte),
        .busy      (busy),
        .ptr       (addr_ptr)
    );

    pwc_latch #(
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) i_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr_latch),
        .wr_en       (accept_byte),
        .wr_off      (addr_ptr[PAGE_W-1:0]),
        .wr_data     (byte_data),
        .rd_off      (commit_off),
        .rd_data     (latch_byte),
        .rd_hit      (latch_hit),
        .any_written (any_buffered)
    );

    assign cur_page    = addr_ptr[ADDR_W-1:PAGE_W];
    assign commit_addr = {cur_page, commit_off};

    pwc_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr_a (commit_addr),
        .rdata_a (old_byte),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );

    assign arr_we    = commit_we;
    assign arr_waddr = commit_addr;
    assign arr_wdata = latch_hit ? latch_byte : old_byte;

    // R4
    we_inside_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (busy && arr_waddr[ADDR_W-1:PAGE_W] == addr_ptr[ADDR_W-1:PAGE_W]));

endmodule

// File: tb/test_page_write_ctrl.sv
`timescale 1ns/1ps
module test_page_write_ctrl;

    localparam int AW = 12;
    localparam int PW = 5;
    localparam int DW = 8;
    localparam int WC = 48;
    localparam int DEPTH = 1 << AW;
    localparam int SLOTS = 1 << PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop_evt = 1'b0;
    logic          wp = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          busy;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    logic [AW-1:0] addr_ptr;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    page_write_ctrl #(
        .ADDR_W (AW), .PAGE_W (PW), .DATA_W (DW), .WC_CYCLES (WC)
    ) i_page_write_ctrl (
        .clk (clk), .rst_n (rst_n), .cmd_start (cmd_start), .cmd_addr (cmd_addr),
        .byte_valid (byte_valid), .byte_data (byte_data), .stop_evt (stop_evt),
        .wp (wp), .rd_addr (rd_addr), .rd_data (rd_data), .busy (busy),
        .arr_we (arr_we), .arr_waddr (arr_waddr), .arr_wdata (arr_wdata),
        .addr_ptr (addr_ptr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] a, input int n);
        return {a[AW-1:PW], PW'((int'(a[PW-1:0]) + n) % SLOTS)};
    endfunction

    task automatic check_page(input logic [AW-1:0] a, input string req);
        for (int k = 0; k < SLOTS; k++) begin
            rd_addr = {a[AW-1:PW], PW'(k)};
            #1;
            check(rd_data == exp_mem[rd_addr], req, "page byte", rd_data, exp_mem[rd_addr]);
        end
    endtask

    // pre_n bytes under a first start (discarded by restart), stray bytes before any start
    task automatic run_cmd(input logic [AW-1:0] a, input int n, input bit wp_v,
                           input bit wp_flip, input bit inject, input int pre_n,
                           input int stray, input string req);
        logic [DW-1:0] pb [SLOTS];
        int   off, cnt, wecnt, wrong_addr;
        bit   commit;
        logic [AW-1:0] p0;
        for (int k = 0; k < SLOTS; k++) pb[k] = exp_mem[{a[AW-1:PW], PW'(k)}];
        p0 = addr_ptr;
        for (int s = 0; s < stray; s++) begin
            byte_valid = 1'b1; byte_data = DW'($urandom); stop_evt = (s == 0);
            @(negedge clk);
        end
        byte_valid = 1'b0; stop_evt = 1'b0;
        if (stray > 0) check(addr_ptr == p0, "R12", "ptr after stray bytes", addr_ptr, p0);
        if (pre_n > 0) begin
            cmd_start = 1'b1; cmd_addr = AW'($urandom); @(negedge clk);
            cmd_start = 1'b0;
            for (int s = 0; s < pre_n; s++) begin
                byte_valid = 1'b1; byte_data = DW'($urandom); @(negedge clk);
            end
            byte_valid = 1'b0;
        end
        cmd_start = 1'b1; cmd_addr = a; @(negedge clk);
        cmd_start = 1'b0;
        check(addr_ptr == a, "R2", "ptr load", addr_ptr, a);
        off = int'(a[PW-1:0]);
        for (int s = 0; s < n; s++) begin
            byte_valid = 1'b1; byte_data = DW'($urandom);
            pb[off] = byte_data; off = (off + 1) % SLOTS;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        check(addr_ptr == next_ptr(a, n), (n > SLOTS) ? "R3" : "R2", "ptr step",
              addr_ptr, next_ptr(a, n));
        wp = wp_v; stop_evt = 1'b1; @(negedge clk);
        stop_evt = 1'b0; wp = 1'b0;
        commit = (n > 0) && !wp_v;
        check(busy == commit, wp_v ? "R6" : ((n == 0) ? "R5" : "R8"),
              "busy after stop", busy, commit);
        cnt = 0; wecnt = 0; wrong_addr = 0;
        while (busy && cnt < 4 * WC) begin
            cnt++;
            if (arr_we) begin
                if (arr_waddr != {a[AW-1:PW], PW'(wecnt)}) wrong_addr++;
                wecnt++;
            end
            if (wp_flip) wp = ~wp;
            if (inject) begin
                cmd_start = 1'b1; cmd_addr = AW'($urandom);
                byte_valid = 1'b1; byte_data = DW'($urandom); stop_evt = ~stop_evt;
            end
            @(negedge clk);
        end
        cmd_start = 1'b0; byte_valid = 1'b0; stop_evt = 1'b0; wp = 1'b0;
        if (commit) begin
            check(cnt == WC, "R8", "busy length", cnt, WC);
            check(wecnt == SLOTS, "R4", "write strobes", wecnt, SLOTS);
            check(wrong_addr == 0, "R4", "strobe address order", wrong_addr, 0);
            for (int k = 0; k < SLOTS; k++) exp_mem[{a[AW-1:PW], PW'(k)}] = pb[k];
        end
        check(addr_ptr == next_ptr(a, n), inject ? "R9" : "R10", "ptr after command",
              addr_ptr, next_ptr(a, n));
        check_page(a, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = $urandom(32'h5eed_0042);
        for (int k = 0; k < DEPTH; k++) exp_mem[k] = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "busy at reset", busy, 0);
        check(arr_we == 1'b0, "R1", "arr_we at reset", arr_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(addr_ptr == '0, "R1", "ptr after reset", addr_ptr, 0);
        check_page(12'h7A0, "R1");

        run_cmd(12'h123, 1,  1'b0, 1'b0, 1'b0, 0, 0, "R4");  // single byte, rest kept
        run_cmd(12'h3FC, 10, 1'b0, 1'b0, 1'b0, 0, 0, "R2");  // offset wrap in page
        run_cmd(12'h047, 40, 1'b0, 1'b0, 1'b0, 0, 0, "R3");  // more than a page
        run_cmd(12'h500, 0,  1'b0, 1'b0, 1'b0, 0, 0, "R5");  // no data bytes
        run_cmd(12'h123, 6,  1'b1, 1'b0, 1'b0, 0, 0, "R6");  // protected
        run_cmd(12'h12A, 3,  1'b0, 1'b0, 1'b0, 0, 0, "R6");  // accepted at once
        run_cmd(12'h9E5, 12, 1'b0, 1'b1, 1'b0, 0, 0, "R7");  // wp toggles in cycle
        run_cmd(12'hC31, 20, 1'b0, 1'b0, 1'b1, 0, 0, "R9");  // traffic during busy
        run_cmd(12'h2D0, 4,  1'b0, 1'b0, 1'b0, 5, 0, "R11"); // restart discards
        run_cmd(12'h611, 7,  1'b0, 1'b0, 1'b0, 0, 3, "R12"); // stray bytes in idle
        run_cmd(12'hFE0, 32, 1'b0, 1'b0, 1'b0, 0, 0, "R10"); // exact page
        for (int t = 0; t < 30; t++) begin
            run_cmd(AW'($urandom), int'($urandom_range(0, 40)),
                    ($urandom_range(0, 4) == 0), $urandom_range(0, 1) == 1,
                    $urandom_range(0, 3) == 0, ($urandom_range(0, 5) == 0) ? 3 : 0,
                    ($urandom_range(0, 5) == 0) ? 2 : 0, "R4");
        end
        for (int k = 0; k < DEPTH; k++) begin   // R4 other pages untouched
            rd_addr = AW'(k);
            #1;
            if (rd_data != exp_mem[k]) check(1'b0, "R4", "array sweep", rd_data, exp_mem[k]);
        end
        check(1'b1, "R4", "array sweep done", 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule